// File: doc/BRIEF.md
# Serial Slave Front End with Hold-Pause Control

This block is the pin-facing half of a serial peripheral slave. It runs on a fast system clock. It oversamples four pins: select, serial clock, hold and serial data in. From these it moves whole bytes in both directions, most significant bit first. The transfer uses clock idle low: data is captured on the rising serial clock edge and the output is updated on the falling edge. A received byte is presented with a one-cycle strobe. The next byte to send is taken from a parallel input.

A master can pause a transfer at any point by pulling the active-low hold pin low while select stays low. The pause starts and ends only while the serial clock is low. If hold moves while the clock is high, the start or end waits for the clock to return low. While paused, the output driver is released, input bits are ignored and the bit position is frozen. The transfer then continues from the very next bit.

Deselecting during a pause clears all transfer state. A busy indication from the internal engine passes through without regard to hold.

Top module: `spi_hold_slave`

## Requirements
- R1: While and after a synchronous reset, with select high, the outputs are `miso_oe`=0, `held_o`=0, `rx_valid`=0 and `rx_word`=0.
- R2: With select low and no pause, one data-in bit is captured on each rising serial clock edge, most significant bit first. After the eighth bit, `rx_word` holds the byte and `rx_valid` is 1 for exactly one system clock.
- R3: `tx_word` is captured when select falls and again at each falling serial clock edge that follows a completed byte. Its bits appear on `miso_o` most significant first, advancing on falling serial clock edges. `miso_oe` is 1 while selected and not paused.
- R4: A pause (`held_o`=1) begins only while select is low, hold is low and the serial clock is low. If hold falls while the clock is high, `held_o` stays 0 until the clock goes low.
- R5: A pause ends only when hold is high and the serial clock is low. If hold rises while the clock is high, `held_o` stays 1 until the clock goes low.
- R6: `miso_oe` drops to 0 as soon as the synchronized hold pin is low, even before the pause formally begins. It stays 0 until the pause has ended.
- R7: Serial clock edges during a pause neither capture data, nor advance the bit count, nor produce `rx_valid`. After the pause the byte continues with its next bit, in both directions.
- R8: Select going high clears the pause, the bit count and both shift registers. A hold fall while select is high has no effect. After reselection with hold still low the block is immediately paused, and it needs hold high to transfer.
- R9: `busy_o` equals `busy_in` delayed by one system clock, whether or not a pause is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Active-low select pin |
| sck_pin | input | 1 | Serial clock pin, idle low |
| hold_n_pin | input | 1 | Active-low pause pin |
| mosi_pin | input | 1 | Serial data in |
| tx_word | input | WORD_W | Next byte to transmit |
| busy_in | input | 1 | Internal operation in progress |
| miso_o | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output driver enable (0 = high impedance) |
| rx_word | output | WORD_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe on byte completion |
| held_o | output | 1 | Pause state active |
| busy_o | output | 1 | Registered busy indication |

## Verification
Some internal faults show up at the ports within a few system clocks of the pin change that exposes them. A pause flag that misses the clock-low qualification shows up that way on `held_o`. A driver that is enabled during a pause shows up on `miso_oe`.

A bit counter that advances during a pause stays hidden until the byte finishes. It then shows up as a wrong `rx_word`, an early or missing `rx_valid`, or a shifted transmit pattern. For that reason every pause scenario completes its byte and compares the whole byte in both directions.

Stale state after a deselect-during-pause appears on the first byte of the next transfer.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
        logic mosi;
    } pins_t;

    localparam int PIN_COUNT = $bits(pins_t);

    // Idle pin levels: deselected, clock low, hold released, data low
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = {1'b1, 1'b0, 1'b1, 1'b0};

    typedef enum logic [1:0] {
        LNK_IDLE = 2'd0,
        LNK_RUN  = 2'd1,
        LNK_HELD = 2'd2
    } link_state_e;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic sel_start;
        logic desel;
    } evt_t;

    function automatic logic pause_may_start(input logic hold_n, input logic sck);
        return (!hold_n) && (!sck);
    endfunction

    function automatic logic pause_may_end(input logic hold_n, input logic sck);
        return hold_n && (!sck);
    endfunction

endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/shp_edge.sv
module shp_edge
    import spi_hold_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output evt_t  ev
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= pins.sck;
            cs_q  <= pins.cs_n;
        end
    end

    always_comb begin
        ev.sck_rise  = pins.sck & ~sck_q;
        ev.sck_fall  = ~pins.sck & sck_q;
        ev.sel_start = ~pins.cs_n & cs_q;
        ev.desel     = pins.cs_n;
    end
endmodule

// File: rtl/shp_hold_fsm.sv
module shp_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pins_t       pins,
    output link_state_e state,
    output logic        run,
    output logic        held,
    output logic        drive_ok
);
    link_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            LNK_IDLE: if (!pins.cs_n) nxt = LNK_RUN;
            LNK_RUN: begin
                if (pins.cs_n)
                    nxt = LNK_IDLE;
                else if (pause_may_start(pins.hold_n, pins.sck))
                    nxt = LNK_HELD;
            end
            LNK_HELD: begin
                if (pins.cs_n)
                    nxt = LNK_IDLE;
                else if (pause_may_end(pins.hold_n, pins.sck))
                    nxt = LNK_RUN;
            end
            default: nxt = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LNK_IDLE;
        else     state <= nxt;
    end

    assign run      = (state == LNK_RUN);
    assign held     = (state == LNK_HELD);
    // Driver released immediately on a low hold pin, even if the pause is deferred
    assign drive_ok = run & pins.hold_n;
endmodule

// File: rtl/shp_shifter.sv
module shp_shifter
    import spi_hold_pkg::*;
#(
    parameter int W = 8,
    localparam int CNT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             ev,
    input  logic             run,
    input  logic             mosi,
    input  logic [W-1:0]     tx_word,
    output logic [W-1:0]     rx_word,
    output logic             rx_strobe,
    output logic             miso,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic [W-1:0] rx_sr;
    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_next;

    assign rx_next = {rx_sr[W-2:0], mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
        end else if (!ev.desel && run && ev.sck_rise && bit_cnt == LAST_BIT) begin
            rx_word <= rx_next;
        end
    end

    always_ff @(posedge clk) begin
        rx_strobe <= 1'b0;
        if (rst || ev.desel) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else begin
            if (ev.sel_start) begin
                tx_sr <= tx_word;
            end
            if (run && ev.sck_rise) begin
                rx_sr <= rx_next;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    rx_strobe <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (run && ev.sck_fall) begin
                if (bit_cnt == '0) tx_sr <= tx_word;
                else               tx_sr <= {tx_sr[W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sr[W-1];
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
    import spi_hold_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_pin,
    input  logic              sck_pin,
    input  logic              hold_n_pin,
    input  logic              mosi_pin,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              busy_in,
    output logic              miso_o,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              held_o,
    output logic              busy_o
);
    logic [PIN_COUNT-1:0] raw_pins;
    logic [PIN_COUNT-1:0] sync_pins;
    pins_t                pins_s;
    evt_t                 ev;
    link_state_e          lnk_state;
    logic                 run;
    logic                 drive_ok;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 cs_s;
    logic                 sck_s;
    logic                 hold_s;

    assign raw_pins = {cs_n_pin, sck_pin, hold_n_pin, mosi_pin};

    shp_sync #(
        .W      (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_pins),
        .q  (sync_pins)
    );

    assign pins_s = pins_t'(sync_pins);
    assign cs_s   = pins_s.cs_n;
    assign sck_s  = pins_s.sck;
    assign hold_s = pins_s.hold_n;

    shp_edge u_edge (
        .clk (clk),
        .rst (rst),
        .pins(pins_s),
        .ev  (ev)
    );

    shp_hold_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins_s),
        .state   (lnk_state),
        .run     (run),
        .held    (held_o),
        .drive_ok(drive_ok)
    );

    shp_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .run      (run),
        .mosi     (pins_s.mosi),
        .tx_word  (tx_word),
        .rx_word  (rx_word),
        .rx_strobe(rx_valid),
        .miso     (miso_o),
        .bit_cnt  (bit_cnt)
    );

    assign miso_oe = drive_ok;

    // Busy path is independent of the pause and of select
    always_ff @(posedge clk) begin
        busy_o <= busy_in;
    end
endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_s,
    input logic             sck_s,
    input logic             hold_s,
    input logic             held_o,
    input logic             miso_oe,
    input logic             rx_valid,
    input logic             busy_in,
    input logic             busy_o,
    input logic [CNT_W-1:0] bit_cnt
);
    AST_ENTRY_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(held_o) |-> ($past(!sck_s) && $past(!hold_s) && $past(!cs_s))); // R4

    AST_EXIT_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(held_o) |-> ($past(cs_s) || ($past(hold_s) && $past(!sck_s)))); // R5

    AST_NO_DRIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        held_o |-> !miso_oe); // R6

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (held_o && !cs_s) |=> $stable(bit_cnt)); // R7

    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> (!held_o && bit_cnt == '0)); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R2

    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        busy_o == $past(busy_in)); // R9
endmodule

bind spi_hold_slave spi_hold_slave_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (cs_s),
    .sck_s   (sck_s),
    .hold_s  (hold_s),
    .held_o  (held_o),
    .miso_oe (miso_oe),
    .rx_valid(rx_valid),
    .busy_in (busy_in),
    .busy_o  (busy_o),
    .bit_cnt (bit_cnt)
);

// File: tb/spi_hold_slave_tb.sv
`timescale 1ns/1ps
module spi_hold_slave_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n_pin = 1'b1;
    logic       sck_pin = 1'b0;
    logic       hold_n_pin = 1'b1;
    logic       mosi_pin = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       busy_in = 1'b0;
    logic       miso_o;
    logic       miso_oe;
    logic [7:0] rx_word;
    logic       rx_valid;
    logic       held_o;
    logic       busy_o;

    int checks = 0;
    int failures = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_hold_slave u_dut (
        .clk       (clk),
        .rst       (rst),
        .cs_n_pin  (cs_n_pin),
        .sck_pin   (sck_pin),
        .hold_n_pin(hold_n_pin),
        .mosi_pin  (mosi_pin),
        .tx_word   (tx_word),
        .busy_in   (busy_in),
        .miso_o    (miso_o),
        .miso_oe   (miso_oe),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .held_o    (held_o),
        .busy_o    (busy_o)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_word;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_rise(input logic b, output logic seen);
        mosi_pin = b;
        wait_clk(HALF);
        seen = miso_o;
        sck_pin = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic bit_fall();
        sck_pin = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic xfer_bits(input logic [7:0] mo, input int first, input int count,
                             inout logic [7:0] seen);
        for (int i = first; i > first - count; i--) begin
            logic s;
            bit_rise(mo[i], s);
            seen[i] = s;
            bit_fall();
        end
    endtask

    task automatic pulse_held(input int n);
        for (int i = 0; i < n; i++) begin
            logic s;
            bit_rise(i[0], s);
            bit_fall();
        end
    endtask

    task automatic t_reset();
        check("R1 miso_oe", miso_oe, 0);
        check("R1 held_o", held_o, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 rx_word", rx_word, 0);
    endtask

    task automatic t_plain();
        logic [7:0] seen = 8'h00;
        int rc;
        tx_word = 8'hA5;
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        tx_word = 8'h5A;
        check("R3 oe selected", miso_oe, 1);
        rc = rx_cnt;
        xfer_bits(8'h3C, 7, 8, seen);
        check("R3 tx byte0", seen, 8'hA5);
        check("R2 rx byte0", rx_last, 8'h3C);
        check("R2 one strobe", rx_cnt, rc + 1);
        xfer_bits(8'h81, 7, 8, seen);
        check("R3 tx byte1", seen, 8'h5A);
        check("R2 rx byte1", rx_last, 8'h81);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_hold_clk_low();
        logic [7:0] seen = 8'h00;
        int rc;
        tx_word = 8'h96;
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        xfer_bits(8'h4B, 7, 3, seen);
        hold_n_pin = 1'b0;
        wait_clk(HALF);
        check("R4 held clk low", held_o, 1);
        check("R6 oe off", miso_oe, 0);
        rc = rx_cnt;
        pulse_held(8);
        check("R7 no strobe in hold", rx_cnt, rc);
        check("R7 still held", held_o, 1);
        hold_n_pin = 1'b1;
        wait_clk(HALF);
        check("R5 exit clk low", held_o, 0);
        check("R5 oe back", miso_oe, 1);
        xfer_bits(8'h4B, 4, 5, seen);
        check("R7 tx resumes", seen, 8'h96);
        check("R7 rx resumes", rx_last, 8'h4B);
        check("R7 one strobe", rx_cnt, rc + 1);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_hold_clk_high();
        logic [7:0] seen = 8'h00;
        logic s;
        tx_word = 8'h3C;
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        xfer_bits(8'hD2, 7, 3, seen);
        bit_rise(1'b1, s);
        seen[4] = s;
        hold_n_pin = 1'b0;
        wait_clk(HALF);
        check("R4 entry deferred", held_o, 0);
        check("R6 oe off early", miso_oe, 0);
        bit_fall();
        check("R4 entry on clk low", held_o, 1);
        pulse_held(3);
        bit_rise(1'b1, s);
        hold_n_pin = 1'b1;
        wait_clk(HALF);
        check("R5 exit deferred", held_o, 1);
        check("R6 oe stays off", miso_oe, 0);
        bit_fall();
        check("R5 exit on clk low", held_o, 0);
        check("R5 oe on", miso_oe, 1);
        xfer_bits(8'hD2, 3, 4, seen);
        check("R7 tx after deferred", seen, 8'h3C);
        check("R7 rx after deferred", rx_last, 8'hD2);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_desel_in_hold();
        logic [7:0] seen = 8'h00;
        int rc;
        tx_word = 8'hFF;
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        xfer_bits(8'hE0, 7, 3, seen);
        hold_n_pin = 1'b0;
        wait_clk(HALF);
        check("R8 held before desel", held_o, 1);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
        check("R8 desel clears hold", held_o, 0);
        check("R8 oe off deselected", miso_oe, 0);
        hold_n_pin = 1'b1;
        tx_word = 8'hC3;
        wait_clk(HALF);
        rc = rx_cnt;
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        check("R8 restart oe", miso_oe, 1);
        xfer_bits(8'h96, 7, 8, seen);
        check("R8 fresh tx", seen, 8'hC3);
        check("R8 fresh rx", rx_last, 8'h96);
        check("R8 single strobe", rx_cnt, rc + 1);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_hold_deselected();
        hold_n_pin = 1'b0;
        wait_clk(HALF);
        check("R8 hold ignored deselected", held_o, 0);
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        check("R8 reselect with hold low", held_o, 1);
        check("R8 no drive hold low", miso_oe, 0);
        hold_n_pin = 1'b1;
        wait_clk(HALF);
        check("R8 hold high resumes", held_o, 0);
        check("R8 drive after release", miso_oe, 1);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_busy_in_hold();
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        busy_in = 1'b1;
        hold_n_pin = 1'b0;
        wait_clk(HALF);
        check("R9 held", held_o, 1);
        check("R9 busy high in hold", busy_o, 1);
        busy_in = 1'b0;
        wait_clk(2);
        check("R9 busy low in hold", busy_o, 0);
        hold_n_pin = 1'b1;
        cs_n_pin = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        wait_clk(4);
        t_reset();
        rst = 1'b0;
        wait_clk(HALF);
        t_reset();
        t_plain();
        t_hold_clk_low();
        t_hold_clk_high();
        t_desel_in_hold();
        t_hold_deselected();
        t_busy_in_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule